// File: doc/BRIEF.md
# Video Test Pattern Generator

This block sits at the head of an image pipeline. It receives a pixel stream with frame valid, line valid, column and row coordinates and a packed RGB pixel. It passes that stream through or replaces its pixels with a synthetic pattern. A 3-bit select input chooses one of three sources: the live image, a grey field at one of six brightness steps, or eight vertical colour bars. A 2-bit ramp input lays a grey ramp over the output. The ramp follows the column, the row or the frame count, and it takes priority over the select input. While any pattern is in effect, the block raises a flag that forces the downstream white-balance gains to unity.

A small state machine tracks the frame and line structure of the input. It has three states. ST_VBLANK is the gap between frames. ST_LINE means a line is active. ST_HBLANK is the gap between lines inside a frame. The transitions are:
- ST_VBLANK to ST_LINE on frame valid with line valid.
- ST_VBLANK to ST_HBLANK on frame valid without line valid.
- ST_LINE to ST_HBLANK when line valid drops.
- ST_HBLANK to ST_LINE when line valid rises.
- ST_LINE or ST_HBLANK back to ST_VBLANK when frame valid drops.

Leaving ST_VBLANK is the frame-start event. Leaving ST_LINE is the line-end event. These two events drive the 16-bit line and frame counters. They also load the select and ramp settings, so a new setting takes effect only at a frame boundary.

Top module: `vtpg_top`

## Requirements
- R1: With select 0 and ramp off in effect, out_pix equals in_pix of one cycle earlier and wb_unity is 0.
- R2: For a select value n from 1 to 6 in effect (ramp off), all three channels carry floor(n*(2^PIX_W-1)/7); with PIX_W=10 the levels are 146, 292, 438, 584, 730 and 876.
- R3: For select 7 in effect (ramp off), the bar index is min(7, floor(8*x/line_width)). Bars 0 to 7 are white, yellow, cyan, green, magenta, red, blue, black. Each channel is either all ones or zero, and out_pix packs red in the top PIX_W bits, then green, then blue.
- R4: A ramp setting of 1, 2 or 3 puts the same grey value on all channels. Setting 1 uses the low PIX_W bits of the column. Setting 2 uses the low PIX_W bits of the row. Setting 3 uses the low PIX_W bits of the frame counter value for the current frame. The ramp overrides the select input; setting 0 turns the ramp off.
- R5: wb_unity is 1 exactly when the select or the ramp setting in effect for the pixel is nonzero, and it has the same latency as the pixel.
- R6: pat_sel and ramp_mode are loaded on the cycle where frame valid rises and apply from that cycle's pixel to the end of the frame; changes at any other time have no effect until the next frame start.
- R7: line_cnt becomes 0 after a frame start. It increments by one after each line end, which is an active line cycle followed by a cycle where frame valid or line valid is low.
- R8: frame_cnt is 0 after reset, increments by one at each frame start and wraps from 65535 to 0.
- R9: out_fv and out_lv equal in_fv and in_lv delayed by one clock cycle.
- R10: While reset is asserted, out_fv, out_lv, out_pix, wb_unity, line_cnt and frame_cnt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_sel | input | 3 | Pattern select: 0 live, 1-6 flat level, 7 bars |
| ramp_mode | input | 2 | Ramp: 0 off, 1 column, 2 row, 3 frame |
| line_width | input | COORD_W (11) | Active pixels per line, for bar spacing |
| in_fv | input | 1 | Input frame valid |
| in_lv | input | 1 | Input line valid |
| in_x | input | COORD_W (11) | Column of the current input pixel |
| in_y | input | COORD_W (11) | Row of the current input pixel |
| in_pix | input | 3*PIX_W (30) | Input pixel {R,G,B} |
| out_fv | output | 1 | Delayed frame valid |
| out_lv | output | 1 | Delayed line valid |
| out_pix | output | 3*PIX_W (30) | Output pixel {R,G,B} |
| wb_unity | output | 1 | Forces white-balance gains to 1.0 |
| line_cnt | output | CNT_W (16) | Line index within the current frame |
| frame_cnt | output | CNT_W (16) | Index of the current frame |

## Verification
Several behaviours are checked by assertions on every cycle:
- Each counter steps, clears or holds correctly around the line-end and frame-start events.
- The held settings never move except at a frame start.
- The valid signals are delayed by exactly one cycle.
- Whenever the unity flag is low, the pixel passes through unchanged.

The pixel values themselves can only be shown by the bench scenarios. These cover the flat levels, the colour-bar spacing for widths that are and are not multiples of eight, and the three ramp kinds. The bench scenarios also cover select changes made in the middle of a frame, lines that end together with the frame, and the 16-bit wrap of the frame counter.

// File: rtl/vtpg_pkg.sv
package vtpg_pkg;

    typedef enum logic [1:0] {
        ST_VBLANK = 2'd0,
        ST_HBLANK = 2'd1,
        ST_LINE   = 2'd2
    } tstate_e;

    typedef enum logic [1:0] {
        RAMP_OFF   = 2'd0,
        RAMP_COL   = 2'd1,
        RAMP_ROW   = 2'd2,
        RAMP_FRAME = 2'd3
    } ramp_e;

    localparam logic [2:0] SEL_LIVE = 3'd0;
    localparam logic [2:0] SEL_BARS = 3'd7;
    localparam int unsigned NUM_BARS = 8;

    // Grey level for a flat-field select code: code * full_scale / 7, floored.
    function automatic int unsigned flat_level(input logic [2:0] code, input int unsigned pw);
        int unsigned full;
        full = (32'd1 << pw) - 32'd1;
        return (32'(code) * full) / 32'd7;
    endfunction

endpackage

// File: rtl/vtpg_timing.sv
module vtpg_timing
    import vtpg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_fv,
    input  logic             in_lv,
    output logic             frame_start,
    output logic             line_end,
    output logic [CNT_W-1:0] line_cnt,
    output logic [CNT_W-1:0] frame_cnt,
    output logic [CNT_W-1:0] frame_idx
);

    tstate_e state_q, state_d;
    logic    active_in;

    assign active_in = in_fv && in_lv;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_VBLANK;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_VBLANK: begin
                if (active_in)  state_d = ST_LINE;
                else if (in_fv) state_d = ST_HBLANK;
            end
            ST_HBLANK: begin
                if (!in_fv)     state_d = ST_VBLANK;
                else if (in_lv) state_d = ST_LINE;
            end
            ST_LINE: begin
                if (!in_fv)     state_d = ST_VBLANK;
                else if (!in_lv) state_d = ST_HBLANK;
            end
            default:            state_d = ST_VBLANK;
        endcase
    end

    // Event outputs decoded from the state and the inputs
    always_comb begin
        frame_start = 1'b0;
        line_end    = 1'b0;
        unique case (state_q)
            ST_VBLANK: frame_start = in_fv;
            ST_LINE:   line_end    = !active_in;
            default: ;
        endcase
        frame_idx = frame_start ? frame_cnt + 1'b1 : frame_cnt;
    end

    // Counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_cnt  <= '0;
            frame_cnt <= '0;
        end else begin
            if (frame_start) begin
                line_cnt  <= '0;
                frame_cnt <= frame_cnt + 1'b1;
            end else if (line_end) begin
                line_cnt  <= line_cnt + 1'b1;
            end
        end
    end

    p_line_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (line_cnt == '0));

    p_line_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (line_cnt == $past(line_cnt) + 1'b1));

    p_frame_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (frame_cnt == $past(frame_cnt) + 1'b1));

    p_frame_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(frame_cnt));

endmodule

// File: rtl/vtpg_bars.sv
module vtpg_bars
    import vtpg_pkg::*;
#(
    parameter int COORD_W = 11
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] width,
    output logic [2:0]         bar_idx
);

    localparam int EW    = COORD_W + 3;
    localparam int NTHR  = NUM_BARS - 1;

    logic [EW-1:0]   x8;
    logic [NTHR-1:0] past_thr;

    assign x8 = {x, 3'b000};

    // Bar k starts where 8*x reaches k*width; one comparator per boundary.
    for (genvar k = 1; k <= NTHR; k++) begin : g_thr
        logic [EW-1:0] thr;
        assign thr             = EW'(width) * EW'(k);
        assign past_thr[k-1]   = (x8 >= thr);
    end

    always_comb begin
        bar_idx = '0;
        for (int i = 0; i < NTHR; i++) begin
            bar_idx = bar_idx + 3'(past_thr[i]);
        end
    end

endmodule

// File: rtl/vtpg_pixgen.sv
module vtpg_pixgen
    import vtpg_pkg::*;
#(
    parameter int PIX_W   = 10,
    parameter int COORD_W = 11,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         pat_sel,
    input  logic [1:0]         ramp_mode,
    input  logic               frame_start,
    input  logic               in_fv,
    input  logic               in_lv,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [3*PIX_W-1:0] in_pix,
    input  logic [2:0]         bar_idx,
    input  logic [CNT_W-1:0]   frame_idx,
    output logic               out_fv,
    output logic               out_lv,
    output logic [3*PIX_W-1:0] out_pix,
    output logic               wb_unity
);

    localparam int PW3 = 3 * PIX_W;

    logic [2:0]     sel_q, eff_sel;
    ramp_e          ramp_q, eff_ramp;
    logic [PIX_W-1:0] ramp_val, flat_val;
    logic [PW3-1:0] bar_px, pix_d;
    logic           active_d;
    logic           primed_q;

    // Settings are captured only at a frame start; the start pixel already uses them.
    always_comb begin
        eff_sel  = frame_start ? pat_sel : sel_q;
        eff_ramp = frame_start ? ramp_e'(ramp_mode) : ramp_q;

        unique case (eff_ramp)
            RAMP_COL:   ramp_val = PIX_W'(in_x);
            RAMP_ROW:   ramp_val = PIX_W'(in_y);
            RAMP_FRAME: ramp_val = PIX_W'(frame_idx);
            default:    ramp_val = '0;
        endcase

        bar_px   = {{PIX_W{~bar_idx[1]}}, {PIX_W{~bar_idx[2]}}, {PIX_W{~bar_idx[0]}}};
        flat_val = PIX_W'(flat_level(eff_sel, PIX_W));

        if (eff_ramp != RAMP_OFF)      pix_d = {3{ramp_val}};
        else if (eff_sel == SEL_LIVE)  pix_d = in_pix;
        else if (eff_sel == SEL_BARS)  pix_d = bar_px;
        else                           pix_d = {3{flat_val}};

        active_d = (eff_sel != SEL_LIVE) || (eff_ramp != RAMP_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= SEL_LIVE;
            ramp_q   <= RAMP_OFF;
            out_fv   <= 1'b0;
            out_lv   <= 1'b0;
            out_pix  <= '0;
            wb_unity <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            if (frame_start) begin
                sel_q  <= pat_sel;
                ramp_q <= ramp_e'(ramp_mode);
            end
            out_fv   <= in_fv;
            out_lv   <= in_lv;
            out_pix  <= pix_d;
            wb_unity <= active_d;
            primed_q <= 1'b1;
        end
    end

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(sel_q) && $stable(ramp_q)));

    p_wb_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (wb_unity == (($past(pat_sel) != 3'd0) || ($past(ramp_mode) != 2'd0))));

    p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !wb_unity) |-> (out_pix == $past(in_pix)));

    p_valid_dly_r9: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> ((out_fv == $past(in_fv)) && (out_lv == $past(in_lv))));

endmodule

// File: rtl/vtpg_top.sv
module vtpg_top
    import vtpg_pkg::*;
#(
    parameter int PIX_W   = 10,
    parameter int COORD_W = 11,
    parameter int CNT_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           pat_sel,
    input  logic [1:0]           ramp_mode,
    input  logic [COORD_W-1:0]   line_width,
    input  logic                 in_fv,
    input  logic                 in_lv,
    input  logic [COORD_W-1:0]   in_x,
    input  logic [COORD_W-1:0]   in_y,
    input  logic [3*PIX_W-1:0]   in_pix,
    output logic                 out_fv,
    output logic                 out_lv,
    output logic [3*PIX_W-1:0]   out_pix,
    output logic                 wb_unity,
    output logic [CNT_W-1:0]     line_cnt,
    output logic [CNT_W-1:0]     frame_cnt
);

    logic             frame_start, line_end;
    logic [CNT_W-1:0] frame_idx;
    logic [2:0]       bar_idx;

    vtpg_timing #(.CNT_W(CNT_W)) timing_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_fv       (in_fv),
        .in_lv       (in_lv),
        .frame_start (frame_start),
        .line_end    (line_end),
        .line_cnt    (line_cnt),
        .frame_cnt   (frame_cnt),
        .frame_idx   (frame_idx)
    );

    vtpg_bars #(.COORD_W(COORD_W)) bars_i (
        .x       (in_x),
        .width   (line_width),
        .bar_idx (bar_idx)
    );

    vtpg_pixgen #(.PIX_W(PIX_W), .COORD_W(COORD_W), .CNT_W(CNT_W)) pixgen_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pat_sel     (pat_sel),
        .ramp_mode   (ramp_mode),
        .frame_start (frame_start),
        .in_fv       (in_fv),
        .in_lv       (in_lv),
        .in_x        (in_x),
        .in_y        (in_y),
        .in_pix      (in_pix),
        .bar_idx     (bar_idx),
        .frame_idx   (frame_idx),
        .out_fv      (out_fv),
        .out_lv      (out_lv),
        .out_pix     (out_pix),
        .wb_unity    (wb_unity)
    );

endmodule

// File: tb/vtpg_top_tb_top.sv
`timescale 1ns/1ps
module vtpg_top_tb_top;

    localparam int PW = 10;
    localparam int CW = 11;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    pat_sel = '0;
    logic [1:0]    ramp_mode = '0;
    logic [CW-1:0] line_width = 11'd16;
    logic          in_fv = 1'b0, in_lv = 1'b0;
    logic [CW-1:0] in_x = '0, in_y = '0;
    logic [3*PW-1:0] in_pix = '0;
    logic          out_fv, out_lv, wb_unity;
    logic [3*PW-1:0] out_pix;
    logic [NW-1:0] line_cnt, frame_cnt;

    always #2.5 clk = ~clk;

    vtpg_top dut_i (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .ramp_mode(ramp_mode),
        .line_width(line_width), .in_fv(in_fv), .in_lv(in_lv), .in_x(in_x),
        .in_y(in_y), .in_pix(in_pix), .out_fv(out_fv), .out_lv(out_lv),
        .out_pix(out_pix), .wb_unity(wb_unity), .line_cnt(line_cnt),
        .frame_cnt(frame_cnt)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int cycles   = 0;

    // Model state
    logic          m_prev_fv = 0, m_prev_act = 0;
    logic [2:0]    m_sel = 0;
    logic [1:0]    m_ramp = 0;
    logic [NW-1:0] m_line = 0, m_frame = 0;
    bit            pend = 0;
    logic [3*PW-1:0] e_pix;
    logic          e_wb, e_fv, e_lv;
    string         e_tag;
    logic [2:0]    cfg_sel = 0;
    logic [1:0]    cfg_ramp = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3*PW-1:0] model_pix(input logic [2:0] s, input logic [1:0] r,
        input logic [CW-1:0] x, input logic [CW-1:0] y, input logic [NW-1:0] f,
        input logic [CW-1:0] w, input logic [3*PW-1:0] p);
        logic [PW-1:0] v;
        logic [2:0] rgb;
        int idx;
        if (r != 0) begin
            v = (r == 1) ? x[PW-1:0] : (r == 2) ? y[PW-1:0] : f[PW-1:0];
            return {v, v, v};
        end
        if (s == 0) return p;
        if (s != 7) begin
            v = PW'((int'(s) * 1023) / 7);
            return {v, v, v};
        end
        idx = (int'(x) * 8) / int'(w);
        if (idx > 7) idx = 7;
        case (idx)
            0: rgb = 3'b111; 1: rgb = 3'b110; 2: rgb = 3'b011; 3: rgb = 3'b010;
            4: rgb = 3'b101; 5: rgb = 3'b100; 6: rgb = 3'b001; default: rgb = 3'b000;
        endcase
        return {{PW{rgb[2]}}, {PW{rgb[1]}}, {PW{rgb[0]}}};
    endfunction

    task automatic verify_pending();
        if (pend) begin
            check({e_tag, " pixel"}, 32'(out_pix), 32'(e_pix));
            check("R5 wb_unity", 32'(wb_unity), 32'(e_wb));
            check("R9 out_fv", 32'(out_fv), 32'(e_fv));
            check("R9 out_lv", 32'(out_lv), 32'(e_lv));
            check("R7 line_cnt", 32'(line_cnt), 32'(m_line));
            check("R8 frame_cnt", 32'(frame_cnt), 32'(m_frame));
        end
    endtask

    task automatic drive(input logic fv, input logic lv, input logic [CW-1:0] x, input logic [CW-1:0] y);
        logic fs, le;
        logic [3*PW-1:0] p;
        @(negedge clk);
        verify_pending();
        p = {$urandom, $urandom}[3*PW-1:0];
        pat_sel = cfg_sel; ramp_mode = cfg_ramp;
        in_fv = fv; in_lv = lv; in_x = x; in_y = y; in_pix = p;
        fs = fv && !m_prev_fv;
        le = m_prev_act && !(fv && lv);
        if (fs) begin
            m_sel = cfg_sel; m_ramp = cfg_ramp; m_frame = m_frame + 1'b1; m_line = '0;
        end else if (le) begin
            m_line = m_line + 1'b1;
        end
        e_pix = model_pix(m_sel, m_ramp, x, y, m_frame, line_width, p);
        e_wb  = (m_sel != 0) || (m_ramp != 0);
        e_fv  = fv; e_lv = lv;
        e_tag = (m_ramp != 0) ? "R4" : (m_sel == 0) ? "R1" : (m_sel == 7) ? "R3" : "R2";
        m_prev_fv = fv; m_prev_act = fv && lv;
        pend = 1;
    endtask

    // One frame: lines of line_width pixels, random gaps; optional mid-frame setting change (R6).
    task automatic frame(input int lines, input bit mid_change, input bit end_with_line);
        for (int l = 0; l < lines; l++) begin
            for (int c = 0; c < int'(line_width); c++) begin
                if (mid_change && l == 0 && c == 1) begin
                    cfg_sel = 3'($urandom); cfg_ramp = 2'($urandom);
                end
                drive(1'b1, 1'b1, CW'(c), CW'(l));
            end
            if (!(end_with_line && l == lines - 1)) begin
                for (int h = 0; h < 1 + int'($urandom_range(2)); h++)
                    drive(1'b1, 1'b0, CW'($urandom), CW'(l));
            end
        end
        for (int v = 0; v < 2 + int'($urandom_range(2)); v++)
            drive(1'b0, 1'b0, CW'($urandom), CW'($urandom));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<190000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 out_fv", 32'(out_fv), 0);
        check("R10 out_lv", 32'(out_lv), 0);
        check("R10 out_pix", 32'(out_pix), 0);
        check("R10 wb_unity", 32'(wb_unity), 0);
        check("R10 line_cnt", 32'(line_cnt), 0);
        check("R10 frame_cnt", 32'(frame_cnt), 0);
        rst_n = 1'b1;

        // R6 directed: live frame with a mid-frame request for bars, then bars next frame
        line_width = 11'd16; cfg_sel = 0; cfg_ramp = 0;
        drive(1'b0, 1'b0, 0, 0);
        drive(1'b1, 1'b1, 0, 0);
        cfg_sel = 3'd7;
        drive(1'b1, 1'b1, 1, 0);
        @(negedge clk);
        check("R6 select ignored mid-frame wb", 32'(wb_unity), 0);
        check("R6 select ignored mid-frame pixel", 32'(out_pix), 32'(in_pix));
        pend = 0;
        m_prev_fv = 1; m_prev_act = 1;
        for (int c = 2; c < 16; c++) drive(1'b1, 1'b1, CW'(c), 0);
        drive(1'b0, 1'b0, 0, 0);
        drive(1'b1, 1'b1, 0, 0);
        @(negedge clk);
        check("R6 select applied next frame wb", 32'(wb_unity), 1);
        check("R3 first bar white", 32'(out_pix), 32'h3FFF_FFFF);
        pend = 0;
        m_prev_fv = 1; m_prev_act = 1;
        drive(1'b0, 1'b0, 0, 0);

        // Directed sweeps: each flat level, each ramp, bar widths 8 and 15
        for (int s = 0; s < 8; s++) begin
            cfg_sel = 3'(s); cfg_ramp = 0; line_width = (s == 7) ? 11'd15 : 11'd12;
            frame(2, 0, s[0]);
        end
        line_width = 11'd8; cfg_sel = 7; frame(2, 0, 0);
        for (int r = 1; r < 4; r++) begin
            cfg_ramp = 2'(r); cfg_sel = 3'($urandom); line_width = 11'd20;
            frame(3, 0, 0);
        end

        // Random frames
        for (int f = 0; f < 40; f++) begin
            line_width = CW'(8 + $urandom_range(32));
            cfg_sel = 3'($urandom);
            cfg_ramp = ($urandom_range(1) == 0) ? 2'd0 : 2'($urandom);
            frame(2 + int'($urandom_range(3)), ($urandom_range(2) == 0), ($urandom_range(1) == 0));
        end

        // R8: minimal frames until the frame counter wraps past 65535
        cfg_ramp = 2'd3; cfg_sel = 0;
        while (m_frame != 16'hFFFF) begin
            drive(1'b1, 1'b0, 0, 0);
            drive(1'b0, 1'b0, 0, 0);
        end
        drive(1'b1, 1'b0, 0, 0);
        @(negedge clk);
        check("R8 frame_cnt wrap", 32'(frame_cnt), 0);
        check("R4 frame ramp at wrap", 32'(out_pix), 0);
        pend = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule